// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Controller

This controller is the digital protection layer for one fixed-frequency switching converter. Every switching period starts with a one-clock strobe. During the period the controller watches a peak-current comparator and a flag that says the output has fallen under its collapse threshold. It gives the high-side switch its gate enable. When the comparator fires, the controller removes the gate enable for the rest of that period.

The controller keeps a count of back-to-back switching periods in which the limit fired. A short is declared only when the count reaches its limit and the output has collapsed at the same time. The switch is then held off for a fixed number of switching periods. When that wait ends, a one-clock restart pulse asks for a new soft-start. One variant discharges the output during the wait and restarts only its own rail. The other variant asks for a restart of every rail in the supply. A parameter chooses the variant. A global enable overrides all of this and sends the controller back to idle.

Top module: `hiccup_fault_ctrl`

## Requirements
- R1: While `cur_limit` is high, `hs_gate` is low in the same clock. Once `cur_limit` has been seen in a switching period, `hs_gate` stays low until the next `cyc_start`.
- R2: While running, `hs_gate` goes high in the clock after each `cyc_start` strobe, unless a limit is active.
- R3: A switching period without any `cur_limit` event clears the consecutive-period count to zero. For example, ten limited periods, one clean period and ten more limited periods do not start a hiccup.
- R4: A hiccup starts at the `cyc_start` that closes a period only when three things hold: that period was limited, the LIMIT_CYCLES−1 periods before it (15 by default) were also limited, and `out_collapsed` is high at that strobe.
- R5: When LIMIT_CYCLES limited periods occur while `out_collapsed` is low, no hiccup starts and the count stays saturated. A later limited period whose closing strobe sees `out_collapsed` high starts the hiccup at that strobe.
- R6: From the strobe that starts the hiccup, `hs_gate` stays low for OFF_CYCLES `cyc_start` strobes (256 by default). The wait ends at the OFF_CYCLES-th strobe after the entry strobe, and switching resumes at the strobe that follows.
- R7: When the wait ends, `restart_req` is high for exactly one clock, in the clock after the final strobe. `restart_all` goes high together with it only when RESTART_ALL=1; otherwise it stays low.
- R8: When OFF_DISCHARGE=1, `dis_en` is high for the whole wait and low at every other time. When OFF_DISCHARGE=0, `dis_en` is always low.
- R9: When `enable` is low, `hs_gate` and `dis_en` are low in that same clock. The controller returns to idle with its count cleared, and after re-enable it switches again from the next strobe.
- R10: The count is cleared when the controller enters and when it leaves a hiccup. Fifteen limited periods with a collapsed output right after a restart therefore do not start a new hiccup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low forces switch off and idle |
| cyc_start | input | 1 | One-clock strobe at the start of each switching period |
| cur_limit | input | 1 | Peak-current comparator output |
| out_collapsed | input | 1 | Output below collapse threshold |
| hs_gate | output | 1 | High-side switch gate enable |
| dis_en | output | 1 | Output discharge enable during the wait |
| restart_req | output | 1 | One-clock soft-start request |
| restart_all | output | 1 | Marks a restart request as covering all rails |

## Verification
The assertions check the relations that must hold in every clock. The gate is low whenever the comparator is high. The gate rises only right after a strobe. Discharge and gate are never on together. A low enable silences every output. A restart pulse lasts one clock and follows a clock in which the gate was off. Only the bench scenarios can show the counting behaviour. This covers the exact period at which a hiccup starts as the run of limited periods and the collapse flag vary, the saturated count, clearing by a clean period, the exact length of the wait, and how the two variants differ in discharge and restart scope.

// File: rtl/hic_pkg.sv
package hic_pkg;
   typedef enum logic [1:0] {
      HIC_IDLE = 2'd0,
      HIC_RUN  = 2'd1,
      HIC_OFF  = 2'd2
   } hic_state_e;
endpackage

// File: rtl/hic_on_latch.sv
// Per-period on latch: set by the period strobe, cleared by a limit trip.
module hic_on_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic strobe,
   input  logic trip,
   output logic on_q,
   output logic seen_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         seen_q <= 1'b0;
      end else if (clr) begin
         on_q   <= 1'b0;
         seen_q <= 1'b0;
      end else if (strobe) begin
         on_q   <= 1'b1;
         seen_q <= 1'b0;
      end else if (trip) begin
         on_q   <= 1'b0;
         seen_q <= 1'b1;
      end
   end
endmodule

// File: rtl/hic_limit_counter.sv
// Saturating count of consecutive limited periods.
module hic_limit_counter #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic strobe,
   input  logic limited,
   output logic at_limit
);
   localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] TOP = W'(LIMIT - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (strobe) begin
         if (!limited) begin
            cnt_q <= '0;
         end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign at_limit = (cnt_q == TOP);
endmodule

// File: rtl/hic_off_timer.sv
// Counts period strobes while the hiccup wait is active.
module hic_off_timer #(
   parameter int unsigned PERIODS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic strobe,
   output logic done
);
   localparam int unsigned W = (PERIODS > 2) ? $clog2(PERIODS) : 1;
   localparam logic [W-1:0] LAST = W'(PERIODS - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active) begin
         cnt_q <= '0;
      end else if (strobe) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = active & strobe & (cnt_q == LAST);
endmodule

// File: rtl/hiccup_fault_ctrl.sv
module hiccup_fault_ctrl
   import hic_pkg::*;
#(
   parameter int unsigned LIMIT_CYCLES  = 16,
   parameter int unsigned OFF_CYCLES    = 256,
   parameter bit          OFF_DISCHARGE = 1'b1,
   parameter bit          RESTART_ALL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cyc_start,
   input  logic cur_limit,
   input  logic out_collapsed,
   output logic hs_gate,
   output logic dis_en,
   output logic restart_req,
   output logic restart_all
);

   generate
      if (LIMIT_CYCLES < 2) begin : g_bad_limit
         $error("LIMIT_CYCLES must be at least 2");
      end
      if (OFF_CYCLES < 2) begin : g_bad_off
         $error("OFF_CYCLES must be at least 2");
      end
   endgenerate

   hic_state_e st_q, st_d;
   logic       running, waiting;
   logic       on_q, seen_q, limited;
   logic       at_limit, enter, off_done;
   logic       latch_clr, cnt_clr;
   logic       restart_q;

   assign running = (st_q == HIC_RUN);
   assign waiting = (st_q == HIC_OFF);
   assign limited = seen_q | cur_limit;
   assign enter   = enable & running & cyc_start & limited & at_limit & out_collapsed;

   assign latch_clr = ~enable | ~running | enter;
   assign cnt_clr   = ~enable | ~running | enter;

   hic_on_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (latch_clr),
      .strobe (cyc_start),
      .trip   (cur_limit),
      .on_q   (on_q),
      .seen_q (seen_q)
   );

   hic_limit_counter #(.LIMIT(LIMIT_CYCLES)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .strobe   (cyc_start),
      .limited  (limited),
      .at_limit (at_limit)
   );

   hic_off_timer #(.PERIODS(OFF_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (enable & waiting),
      .strobe (cyc_start),
      .done   (off_done)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         HIC_IDLE: if (enable) st_d = HIC_RUN;
         HIC_RUN: begin
            if (!enable)    st_d = HIC_IDLE;
            else if (enter) st_d = HIC_OFF;
         end
         HIC_OFF: begin
            if (!enable)       st_d = HIC_IDLE;
            else if (off_done) st_d = HIC_RUN;
         end
         default: st_d = HIC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= HIC_IDLE;
         restart_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         restart_q <= enable & off_done;
      end
   end

   assign hs_gate     = enable & running & on_q & ~cur_limit;
   assign restart_req = restart_q;

   generate
      if (OFF_DISCHARGE) begin : g_dis
         assign dis_en = enable & waiting;
      end else begin : g_nodis
         assign dis_en = 1'b0;
      end
      if (RESTART_ALL) begin : g_all
         assign restart_all = restart_q;
      end else begin : g_local
         assign restart_all = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hic_checker.sv
module hic_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic cyc_start,
   input logic cur_limit,
   input logic hs_gate,
   input logic dis_en,
   input logic restart_req,
   input logic restart_all
);
   // R1
   trip_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_limit |-> !hs_gate);

   // R2
   gate_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> $past(cyc_start));

   // R8
   dis_gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_en |-> !hs_gate);

   // R9
   disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!hs_gate && !dis_en));

   // R7
   restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !restart_req);

   // R7
   scope_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_all |-> restart_req);

   // R6
   restart_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> $past(!hs_gate));
endmodule

bind hiccup_fault_ctrl hic_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .cyc_start   (cyc_start),
   .cur_limit   (cur_limit),
   .hs_gate     (hs_gate),
   .dis_en      (dis_en),
   .restart_req (restart_req),
   .restart_all (restart_all)
);

// File: tb/tb_hiccup_fault_ctrl.sv
module tb_hiccup_fault_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic cyc_start = 1'b0;
   logic cur_limit = 1'b0;
   logic out_collapsed = 1'b0;
   logic hs_gate, dis_en, restart_req, restart_all;
   logic hv_gate, hv_dis, hv_rst, hv_all;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // sampled values of the last switching period
   logic s_on, s_dis, s_rst, s_all, s_hv_dis, s_hv_all, s_trip, s_late, s_rst2;

   always #10 clk = ~clk;

   hiccup_fault_ctrl #(.LIMIT_CYCLES(16), .OFF_CYCLES(256),
                       .OFF_DISCHARGE(1'b1), .RESTART_ALL(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_start(cyc_start),
      .cur_limit(cur_limit), .out_collapsed(out_collapsed),
      .hs_gate(hs_gate), .dis_en(dis_en), .restart_req(restart_req),
      .restart_all(restart_all));

   hiccup_fault_ctrl #(.LIMIT_CYCLES(16), .OFF_CYCLES(256),
                       .OFF_DISCHARGE(1'b0), .RESTART_ALL(1'b1)) dut_hv (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_start(cyc_start),
      .cur_limit(cur_limit), .out_collapsed(out_collapsed),
      .hs_gate(hv_gate), .dis_en(hv_dis), .restart_req(hv_rst),
      .restart_all(hv_all));

   task automatic chk(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
      end
   endtask

   // One switching period of four clocks; starts and ends at a falling edge.
   task automatic sw_cycle(input logic lim, input logic low);
      cyc_start = 1'b1;
      @(posedge clk); @(negedge clk);
      cyc_start = 1'b0;
      s_on = hs_gate; s_dis = dis_en; s_rst = restart_req; s_all = restart_all;
      s_hv_dis = hv_dis; s_hv_all = hv_all;
      cur_limit = lim;
      #1 s_trip = hs_gate;
      @(posedge clk); @(negedge clk);
      cur_limit = 1'b0;
      s_late = hs_gate; s_rst2 = restart_req;
      out_collapsed = low;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
   endtask

   task automatic reenable();
      enable = 1'b0;
      @(posedge clk); @(negedge clk);
      enable = 1'b1;
      @(posedge clk); @(negedge clk);
   endtask

   // k limited periods then clean ones; hic tells whether a hiccup is expected.
   task automatic scenario(input int k, input logic low, input logic hic);
      int n_last;
      reenable();
      n_last = hic ? 274 : k + 1;
      for (int i = 1; i <= n_last; i++) begin
         logic lim, e_off, e_rst, e_on;
         lim   = (i <= k);
         e_off = hic && (i >= 17) && (i < 273);
         e_rst = hic && (i == 273);
         e_on  = !e_off && !e_rst;
         sw_cycle(lim, low);
         chk("R4 R6 R2 gate at period start", s_on, e_on);
         chk("R8 discharge", s_dis, e_off);
         chk("R8 discharge absent in all-rail variant", s_hv_dis, 1'b0);
         chk("R7 restart pulse", s_rst, e_rst);
         chk("R7 local variant restart_all", s_all, 1'b0);
         chk("R7 all-rail variant restart_all", s_hv_all, e_rst);
         chk("R7 restart width", s_rst2, 1'b0);
         if (lim && e_on) begin
            chk("R1 gate cut by limit", s_trip, 1'b0);
            chk("R1 gate stays off in period", s_late, 1'b0);
         end
      end
   endtask

   initial begin
      #4_000_000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("reset hs_gate", hs_gate, 1'b0);
      chk("reset dis_en", dis_en, 1'b0);
      chk("reset restart_req", restart_req, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 sweep over run length and collapse flag
      for (int k = 0; k <= 18; k++) begin
         for (int lw = 0; lw <= 1; lw++) begin
            scenario(k, lw[0], (lw == 1) && (k >= 16));
         end
      end

      // R10: right after a restart, 15 limited collapsed periods do not trip
      scenario(16, 1'b1, 1'b1);
      for (int i = 1; i <= 17; i++) begin
         sw_cycle(i <= 15, 1'b1);
         chk("R10 no re-entry after restart", s_on, 1'b1);
         chk("R10 no discharge", s_dis, 1'b0);
      end

      // R5: saturation with output healthy, then collapse
      reenable();
      for (int i = 1; i <= 21; i++) begin
         sw_cycle(1'b1, 1'b0);
         chk("R5 saturated, no hiccup", s_on, 1'b1);
      end
      sw_cycle(1'b1, 1'b1);
      chk("R5 still on before collapse strobe", s_on, 1'b1);
      sw_cycle(1'b0, 1'b1);
      chk("R5 hiccup at collapse strobe gate", s_on, 1'b0);
      chk("R5 hiccup at collapse strobe discharge", s_dis, 1'b1);

      // R9: disable during the wait
      enable = 1'b0;
      #1;
      chk("R9 gate low on disable", hs_gate, 1'b0);
      chk("R9 discharge low on disable", dis_en, 1'b0);
      @(posedge clk); @(negedge clk);
      enable = 1'b1;
      @(posedge clk); @(negedge clk);
      sw_cycle(1'b0, 1'b1);
      chk("R9 switching after re-enable", s_on, 1'b1);
      chk("R9 idle cleared wait", s_dis, 1'b0);
      // count cleared by disable: 15 limited collapsed periods must not trip
      for (int i = 1; i <= 17; i++) begin
         sw_cycle(i <= 15, 1'b1);
         chk("R9 count cleared by disable", s_on, 1'b1);
      end

      // R3: a clean period breaks the run
      reenable();
      for (int i = 1; i <= 24; i++) begin
         sw_cycle(i != 11, 1'b1);
         chk("R3 clean period clears count", s_on, 1'b1);
         chk("R3 no discharge", s_dis, 1'b0);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule